// File: doc/BRIEF.md
# SPI Frame Sequencer with Automatic Chip-Select

This block sits between a pair of word FIFOs and a bit-level SPI shifter. It pulls one word at a time from the transmit FIFO and hands it to the shifter with a one-cycle start pulse. It waits for the shifter's done pulse and then writes the returned word into the receive FIFO. Each frame is counted against a programmed burst length. The block drives a single active-low chip-select without software involvement.

Software writes a 32-bit control word. The word carries an enable, a burst length and a hold-select flag. When hold-select is clear, chip-select returns high after every frame. When it is set, chip-select stays low until the burst length is used up. At the end of each burst the remaining count reloads from the control word, and the transmit-done and receive-ready flags are raised. A one-cycle event also goes to the interrupt unit. A separate 6-bit frame-size register is kept here for the shifter.

Writing the control word with its top bit set restores every register to its reset value. Serial clocking and bit shifting are done elsewhere.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset the control word reads 0x80000102, which means enable clear and burst length 1. The frame size reads 4, `cs_n` is high, both status flags are low and no receive push occurs.
- R2: A control write with bit 31 clear stores the whole word and loads the remaining count from bits 23:8. A control write with bit 31 set restores the R1 state instead.
- R3: A frame starts only while enable (control bit 0) is set, the transmit FIFO is not empty and the remaining count is non-zero. Otherwise `cs_n` stays high and no start pulse is issued.
- R4: Each frame pulls `cs_n` low and pops one word. One cycle after `cs_n` falls, the block issues a one-cycle `shf_start` carrying that word. The word returned with `shf_done` is pushed to the receive FIFO two cycles after the cycle in which done is high, and each pushed value equals the returned word.
- R5: With hold-select (control bit 26) clear, `cs_n` rises after every frame and stays high for at least one full cycle before the next frame.
- R6: With hold-select set, `cs_n` stays low between the frames of a burst and rises only when the count is used up.
- R7: When the last frame of a burst completes, several things happen in the same cycle. The count reloads from control bits 23:8, `cs_n` goes high, both status flags go high and `ev_done` pulses for one cycle. If words remain, transfers then continue with the reloaded count.
- R8: The start of every frame clears both status flags.
- R9: If the receive FIFO is full when a word returns, the word is dropped and `ev_ovf` pulses. The frame still counts toward the burst.
- R10: A frame-size write takes effect only while enable is clear and the value is at most 32. Any other such write leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| fsz_wr | input | 1 | Frame-size write strobe |
| fsz_wdata | input | 6 | Frame-size write data |
| cfg_q | output | 32 | Current control word |
| fsz_q | output | 6 | Current frame size |
| txf_empty | input | 1 | Transmit FIFO empty (first-word fall-through) |
| txf_rdata | input | DATA_W | Transmit FIFO head word |
| txf_pop | output | 1 | Transmit FIFO pop |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_wdata | output | DATA_W | Receive FIFO push data |
| shf_start | output | 1 | One-cycle shifter start |
| shf_tx | output | DATA_W | Word to shift out |
| shf_done | input | 1 | One-cycle shifter completion |
| shf_rx | input | DATA_W | Word shifted in, valid with done |
| cs_n | output | 1 | Active-low chip-select |
| st_txdone | output | 1 | Transmit-done status flag |
| st_rxrdy | output | 1 | Receive-ready status flag |
| ev_done | output | 1 | Burst-complete event pulse |
| ev_ovf | output | 1 | Receive-overflow event pulse |

## Verification
All outputs are registered, so every result appears a fixed number of cycles after its cause:
- A register write is visible one cycle after its strobe.
- `cs_n` falls one cycle after the start conditions hold, and `shf_start` follows one cycle after that.
- A receive push comes two cycles after the done cycle.
- The burst flags, `ev_done` and the `cs_n` rise all land on the same edge as that push.

The bench samples on the falling clock edge and stamps each event with a cycle count. It therefore checks the fall-to-start distance exactly. It checks burst totals such as pushes, chip-select falls, done events and the final flag levels only after a settling window far longer than a burst. The bound assertions check the same-edge and one-cycle relations continuously.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 0;
  localparam int HOLD_BIT = 26;
  localparam int SRST_BIT = 31;
  localparam int CNT_LSB  = 8;
  localparam int CNT_W    = 16;
  localparam int FSZ_W    = 6;

  localparam logic [CFG_W-1:0] CFG_RST = 32'h8000_0102;
  localparam logic [FSZ_W-1:0] FSZ_RST = 6'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_XFER,
    ST_STORE,
    ST_DEASSERT
  } seq_state_t;
endpackage

// File: rtl/spi_seq_cfg.sv
module spi_seq_cfg
  import spi_seq_pkg::*;
#(
  parameter int FSZ_MAX = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             fsz_wr,
  input  logic [FSZ_W-1:0] fsz_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [FSZ_W-1:0] fsz_q,
  output logic             soft_rst
);
  logic fsz_ok;

  assign soft_rst = cfg_wr & cfg_wdata[SRST_BIT];
  assign fsz_ok   = fsz_wr & ~cfg_q[EN_BIT] & (int'(fsz_wdata) <= FSZ_MAX);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_q <= CFG_RST;
      fsz_q <= FSZ_RST;
    end else begin
      if (cfg_wr) cfg_q <= cfg_wdata;
      if (fsz_ok) fsz_q <= fsz_wdata;
    end
  end
endmodule

// File: rtl/spi_seq_cnt.sv
module spi_seq_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic [W-1:0] reload_val,
  output logic         nz,
  output logic         last
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  assign nz   = |cnt;
  assign last = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ONE;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec && nz) begin
      cnt <= last ? reload_val : cnt - ONE;
    end
  end
endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              hold,
  input  logic              cnt_nz,
  input  logic              cnt_last,
  output logic              cnt_dec,
  input  logic              txf_empty,
  input  logic [DATA_W-1:0] txf_rdata,
  output logic              txf_pop,
  input  logic              rxf_full,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_wdata,
  output logic              shf_start,
  output logic [DATA_W-1:0] shf_tx,
  input  logic              shf_done,
  input  logic [DATA_W-1:0] shf_rx,
  output logic              cs_n,
  output logic              st_txdone,
  output logic              st_rxrdy,
  output logic              ev_done,
  output logic              ev_ovf
);
  seq_state_t state;

  assign cnt_dec = (state == ST_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cs_n      <= 1'b1;
      txf_pop   <= 1'b0;
      shf_start <= 1'b0;
      shf_tx    <= '0;
      rxf_push  <= 1'b0;
      rxf_wdata <= '0;
      st_txdone <= 1'b0;
      st_rxrdy  <= 1'b0;
      ev_done   <= 1'b0;
      ev_ovf    <= 1'b0;
    end else begin
      txf_pop   <= 1'b0;
      shf_start <= 1'b0;
      rxf_push  <= 1'b0;
      ev_done   <= 1'b0;
      ev_ovf    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (en && !txf_empty && cnt_nz) begin
            cs_n      <= 1'b0;
            txf_pop   <= 1'b1;
            shf_tx    <= txf_rdata;
            st_txdone <= 1'b0;
            st_rxrdy  <= 1'b0;
            state     <= ST_ASSERT;
          end
        end
        ST_ASSERT: begin
          shf_start <= 1'b1;
          state     <= ST_XFER;
        end
        ST_XFER: begin
          if (shf_done) begin
            rxf_wdata <= shf_rx;
            state     <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (rxf_full) ev_ovf <= 1'b1;
          else          rxf_push <= 1'b1;
          if (cnt_last) begin
            cs_n      <= 1'b1;
            st_txdone <= 1'b1;
            st_rxrdy  <= 1'b1;
            ev_done   <= 1'b1;
            state     <= ST_DEASSERT;
          end else if (!hold) begin
            cs_n  <= 1'b1;
            state <= ST_DEASSERT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DEASSERT: state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_seq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FSZ_MAX = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fsz_wr,
  input  logic [5:0]        fsz_wdata,
  output logic [31:0]       cfg_q,
  output logic [5:0]        fsz_q,
  input  logic              txf_empty,
  input  logic [DATA_W-1:0] txf_rdata,
  output logic              txf_pop,
  input  logic              rxf_full,
  output logic              rxf_push,
  output logic [DATA_W-1:0] rxf_wdata,
  output logic              shf_start,
  output logic [DATA_W-1:0] shf_tx,
  input  logic              shf_done,
  input  logic [DATA_W-1:0] shf_rx,
  output logic              cs_n,
  output logic              st_txdone,
  output logic              st_rxrdy,
  output logic              ev_done,
  output logic              ev_ovf
);
  logic soft_rst;
  logic loc_rst;
  logic cnt_load;
  logic cnt_dec;
  logic cnt_nz;
  logic cnt_last;

  assign loc_rst  = rst | soft_rst;
  assign cnt_load = cfg_wr & ~cfg_wdata[SRST_BIT];

  spi_seq_cfg #(.FSZ_MAX(FSZ_MAX)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .fsz_wr    (fsz_wr),
    .fsz_wdata (fsz_wdata),
    .cfg_q     (cfg_q),
    .fsz_q     (fsz_q),
    .soft_rst  (soft_rst)
  );

  spi_seq_cnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (loc_rst),
    .load       (cnt_load),
    .load_val   (cfg_wdata[CNT_LSB +: CNT_W]),
    .dec        (cnt_dec),
    .reload_val (cfg_q[CNT_LSB +: CNT_W]),
    .nz         (cnt_nz),
    .last       (cnt_last)
  );

  spi_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst       (loc_rst),
    .en        (cfg_q[EN_BIT]),
    .hold      (cfg_q[HOLD_BIT]),
    .cnt_nz    (cnt_nz),
    .cnt_last  (cnt_last),
    .cnt_dec   (cnt_dec),
    .txf_empty (txf_empty),
    .txf_rdata (txf_rdata),
    .txf_pop   (txf_pop),
    .rxf_full  (rxf_full),
    .rxf_push  (rxf_push),
    .rxf_wdata (rxf_wdata),
    .shf_start (shf_start),
    .shf_tx    (shf_tx),
    .shf_done  (shf_done),
    .shf_rx    (shf_rx),
    .cs_n      (cs_n),
    .st_txdone (st_txdone),
    .st_rxrdy  (st_rxrdy),
    .ev_done   (ev_done),
    .ev_ovf    (ev_ovf)
  );
endmodule

// File: rtl/spi_frame_seq_chk.sv
module spi_frame_seq_chk #(
  parameter int FSZ_MAX = 32
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_en,
  input logic [5:0] fsz_q,
  input logic       cs_n,
  input logic       shf_start,
  input logic       shf_done,
  input logic       rxf_push,
  input logic       rxf_full,
  input logic       ev_done,
  input logic       ev_ovf,
  input logic       st_txdone,
  input logic       st_rxrdy
);
  AST_CS_FALL_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(cfg_en)); // R3

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    shf_start |=> !shf_start); // R4

  AST_START_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    shf_start |-> !cs_n); // R4

  AST_PUSH_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    rxf_push |-> $past(shf_done, 2)); // R4

  AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> cs_n); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> !ev_done); // R7

  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> (cs_n && st_txdone && st_rxrdy)); // R7

  AST_OVF_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    ev_ovf |-> (!rxf_push && $past(rxf_full))); // R9

  AST_FSZ_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(fsz_q) <= FSZ_MAX); // R10
endmodule

bind spi_frame_seq spi_frame_seq_chk #(.FSZ_MAX(FSZ_MAX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_en    (cfg_q[0]),
  .fsz_q     (fsz_q),
  .cs_n      (cs_n),
  .shf_start (shf_start),
  .shf_done  (shf_done),
  .rxf_push  (rxf_push),
  .rxf_full  (rxf_full),
  .ev_done   (ev_done),
  .ev_ovf    (ev_ovf),
  .st_txdone (st_txdone),
  .st_rxrdy  (st_rxrdy)
);

// File: tb/tb_spi_frame_seq.sv
module tb_spi_frame_seq;
  localparam int DW  = 32;
  localparam int LAT = 3;
  localparam int NV  = 6;
  // count, hold, words in -> pushes, cs falls, done events, final cs_n, final txdone
  localparam int V_CNT  [NV] = '{1, 3, 2, 4, 0, 2};
  localparam int V_HOLD [NV] = '{0, 1, 1, 0, 0, 1};
  localparam int V_NW   [NV] = '{3, 3, 5, 3, 2, 4};
  localparam int E_PUSH [NV] = '{3, 3, 5, 3, 0, 4};
  localparam int E_FALL [NV] = '{3, 1, 3, 3, 0, 2};
  localparam int E_DONE [NV] = '{3, 1, 2, 0, 0, 2};
  localparam int E_CS   [NV] = '{1, 1, 0, 1, 1, 1};
  localparam int E_FLAG [NV] = '{1, 1, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic fsz_wr = 1'b0;
  logic [5:0] fsz_wdata = '0;
  logic [31:0] cfg_q;
  logic [5:0] fsz_q;
  logic txf_empty;
  logic [DW-1:0] txf_rdata;
  logic txf_pop;
  logic rxf_full = 1'b0;
  logic rxf_push;
  logic [DW-1:0] rxf_wdata;
  logic shf_start;
  logic [DW-1:0] shf_tx;
  logic shf_done;
  logic [DW-1:0] shf_rx;
  logic cs_n, st_txdone, st_rxrdy, ev_done, ev_ovf;

  always #4 clk = ~clk;

  spi_frame_seq #(.DATA_W(DW)) dut (.*);

  // transmit FIFO model
  logic [DW-1:0] txq [64];
  int tx_tail = 0;
  int tx_head;
  logic tx_flush = 1'b0;
  assign txf_empty = (tx_head == tx_tail);
  assign txf_rdata = txq[tx_head[5:0]];
  always @(posedge clk) begin
    if (rst)           tx_head <= 0;
    else if (tx_flush) tx_head <= tx_tail;
    else if (txf_pop)  tx_head <= tx_head + 1;
  end

  // shifter model: returns the inverted word LAT cycles after start
  int sh_cnt;
  logic [DW-1:0] sh_word;
  always @(posedge clk) begin
    if (rst) begin
      sh_cnt <= 0; shf_done <= 1'b0; shf_rx <= '0; sh_word <= '0;
    end else begin
      shf_done <= 1'b0;
      if (shf_start) begin
        sh_cnt <= LAT; sh_word <= shf_tx;
      end else if (sh_cnt > 1) begin
        sh_cnt <= sh_cnt - 1;
      end else if (sh_cnt == 1) begin
        sh_cnt <= 0; shf_done <= 1'b1; shf_rx <= ~sh_word;
      end
    end
  end

  // monitor, sampled on the falling edge
  int cyc = 0, m_push = 0, m_fall = 0, m_done = 0, m_ovf = 0, m_start = 0;
  int fall_cyc = 0, start_cyc = 0;
  logic prev_cs = 1'b1;
  logic [DW-1:0] rx_log [128];
  always @(negedge clk) begin
    cyc++;
    if (rxf_push === 1'b1) begin
      if (m_push < 128) rx_log[m_push] = rxf_wdata;
      m_push++;
    end
    if (prev_cs === 1'b1 && cs_n === 1'b0) begin m_fall++; fall_cyc = cyc; end
    if (shf_start === 1'b1) begin m_start++; start_cyc = cyc; end
    if (ev_done === 1'b1) m_done++;
    if (ev_ovf === 1'b1) m_ovf++;
    prev_cs = cs_n;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask
  task automatic fsz_write(input logic [5:0] v);
    @(negedge clk); fsz_wr = 1'b1; fsz_wdata = v;
    @(negedge clk); fsz_wr = 1'b0;
  endtask
  task automatic push_tx(input logic [DW-1:0] w);
    txq[tx_tail[5:0]] = w; tx_tail++;
  endtask
  task automatic flush_tx();
    @(negedge clk); tx_flush = 1'b1;
    @(negedge clk); tx_flush = 1'b0;
  endtask
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] word_of(input int v, input int i);
    return 32'hC0DE_0000 + 32'(v << 8) + 32'(i);
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    int bp, bf, bd, bo, bs;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 cfg reset", cfg_q, 32'h8000_0102);
    chk("R1 fsz reset", 32'(fsz_q), 32'd4);
    chk("R1 cs_n reset", 32'(cs_n), 32'd1);
    chk("R1 flags reset", {30'd0, st_txdone, st_rxrdy}, 32'd0);
    chk("R1 no push", 32'(m_push), 32'd0);

    // frame size register
    fsz_write(6'd16); wait_cyc(1);
    chk("R10 fsz 16 accepted", 32'(fsz_q), 32'd16);
    fsz_write(6'd33); wait_cyc(1);
    chk("R10 fsz 33 rejected", 32'(fsz_q), 32'd16);
    fsz_write(6'd32); wait_cyc(1);
    chk("R10 fsz 32 accepted", 32'(fsz_q), 32'd32);
    cfg_write(32'h0000_0001); // enabled, count 0
    fsz_write(6'd8); wait_cyc(1);
    chk("R10 fsz locked while enabled", 32'(fsz_q), 32'd32);
    cfg_write(32'h0000_0000);

    // vector table
    for (int v = 0; v < NV; v++) begin
      flush_tx();
      cfg_write(32'h8000_0000);
      wait_cyc(1);
      if (v == 0) begin
        chk("R2 soft reset cfg", cfg_q, 32'h8000_0102);
        chk("R2 soft reset fsz", 32'(fsz_q), 32'd4);
      end
      bp = m_push; bf = m_fall; bd = m_done;
      for (int i = 0; i < V_NW[v]; i++) push_tx(word_of(v, i));
      cfg_write((32'(V_CNT[v]) << 8) | (32'(V_HOLD[v]) << 26) | 32'h1);
      wait_cyc(150);
      chk($sformatf("R3 R4 v%0d pushes", v), 32'(m_push - bp), 32'(E_PUSH[v]));
      for (int i = 0; i < E_PUSH[v]; i++)
        chk($sformatf("R4 v%0d rx word %0d", v, i), rx_log[bp + i], ~word_of(v, i));
      chk($sformatf("R5 R6 v%0d cs falls", v), 32'(m_fall - bf), 32'(E_FALL[v]));
      chk($sformatf("R7 v%0d done events", v), 32'(m_done - bd), 32'(E_DONE[v]));
      chk($sformatf("R6 R7 v%0d final cs_n", v), 32'(cs_n), 32'(E_CS[v]));
      chk($sformatf("R7 R8 v%0d txdone", v), 32'(st_txdone), 32'(E_FLAG[v]));
      chk($sformatf("R7 R8 v%0d rxrdy", v), 32'(st_rxrdy), 32'(E_FLAG[v]));
    end

    // disabled controller holds off, then runs
    flush_tx();
    cfg_write(32'h8000_0000);
    bp = m_push; bs = m_start;
    push_tx(word_of(9, 0)); push_tx(word_of(9, 1));
    cfg_write(32'h0000_0200);
    wait_cyc(60);
    chk("R2 cfg stored", cfg_q, 32'h0000_0200);
    chk("R3 no push while disabled", 32'(m_push - bp), 32'd0);
    chk("R3 no start while disabled", 32'(m_start - bs), 32'd0);
    chk("R3 cs_n high while disabled", 32'(cs_n), 32'd1);
    cfg_write(32'h0000_0201);
    wait_cyc(80);
    chk("R3 pushes once enabled", 32'(m_push - bp), 32'd2);
    chk("R4 start one cycle after cs fall", 32'(start_cyc - fall_cyc), 32'd1);
    chk("R4 rx word a", rx_log[bp], ~word_of(9, 0));
    chk("R4 rx word b", rx_log[bp + 1], ~word_of(9, 1));

    // receive FIFO full
    flush_tx();
    cfg_write(32'h8000_0000);
    rxf_full = 1'b1;
    bp = m_push; bo = m_ovf; bd = m_done;
    push_tx(word_of(10, 0));
    cfg_write(32'h0000_0101);
    wait_cyc(60);
    chk("R9 word dropped", 32'(m_push - bp), 32'd0);
    chk("R9 overflow event", 32'(m_ovf - bo), 32'd1);
    chk("R9 frame still counted", 32'(m_done - bd), 32'd1);
    chk("R9 txdone raised", 32'(st_txdone), 32'd1);
    rxf_full = 1'b0;

    finish_run();
  end
endmodule